// File: doc/BRIEF.md
# Chained DMA Tag Sequencer

This block drives one DMA channel through a linked list of 64-bit tags held in memory. Software writes a control word that selects chain mode and sets the start bit, along with the address of the first tag. The sequencer reads a tag, splits it into a quadword count, a type, an interrupt flag and an address. It then asks an external data mover for one quadword at a time, handing it the address of each one. When the count reaches zero, it decides where the next tag is or whether the chain has finished.

Each of the eight tag types sets two things: the data source, which is either the quadwords right after the tag or the tag's own address field, and how the next tag is found. The next tag can follow the data, follow the tag, sit at the address field, or come from a two-entry return stack that call and return tags push and pop. All addresses are quadword indices. Bit 31 marks the scratchpad space, where increments wrap inside a small window and never carry upward. The data mover, stall control, bus arbitration and interleave mode are outside this block.

Top module: `dma_chain_seq`

## Requirements
- R1: After reset, ctrl_o is zero and tag_req_o, xfer_valid_o, done_o, irq_o and err_o are all low.
- R2: A control write is accepted only while the channel is stopped. It stores direction (bit 0), mode (bits 3:2), stack pointer (bits 5:4, a written 3 is stored as 2), tag-transfer enable (bit 6) and tag-interrupt enable (bit 7). Start (bit 8) is set, and tadr_i latched as the first tag address, only when the mode written is 1 (chain). With any other mode, start stays 0 and no tag is fetched.
- R3: A tag carries the count in bits 15:0, the type in bits 30:28, the IRQ flag in bit 31 and the address in bits 63:32. On each tag read, ctrl_o[31:16] takes tag bits 31:16.
- R4: Type 1 moves the quadwords after the tag, and the next tag follows that data. Type 2 moves the quadwords after the tag, and the next tag is at the address field. Type 7 moves the quadwords after the tag and then stops.
- R5: Types 3 and 4 move quadwords from the address field, and the next tag is the one after the current tag. Type 0 moves quadwords from the address field and then stops.
- R6: Type 5 moves the quadwords after the tag, pushes the address just past that data, increments the stack pointer and jumps to the address field. Type 6 with a non-zero stack pointer moves the quadwords after the tag, decrements the pointer and fetches the next tag from the popped address.
- R7: A type 5 tag read while the stack pointer is 2 sets err_o, clears start, moves no quadwords and gives no done pulse.
- R8: A type 6 tag read while the stack pointer is 0 moves its quadwords and then ends the chain.
- R9: When tag-interrupt enable is set and the tag's IRQ flag is 1, the channel stops after that tag's data and pulses irq_o together with done_o. When tag-interrupt enable is clear, the IRQ flag has no effect.
- R10: With tag-transfer enable set, each tag is first offered to the mover as one transfer at the tag's own address, with xfer_tag_o high. Data transfers follow with xfer_tag_o low.
- R11: When address bit 31 is set, a one-quadword step increments bits SPR_AW-1:0 modulo 2^SPR_AW, clears bits 30:SPR_AW and keeps bit 31.
- R12: One quadword moves per cycle in which xfer_valid_o and xfer_ready_i are both high. The offered address holds while ready is low. Tag fetch and transfer requests are never raised together.
- R13: When a chain ends, start clears and done_o is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 32 | Control write data |
| tadr_i | input | 32 | First tag address, latched when start is accepted |
| ctrl_o | output | 32 | Control register readback |
| tag_req_o | output | 1 | Tag read request |
| tag_addr_o | output | 32 | Tag read address (quadword units) |
| tag_valid_i | input | 1 | Tag data valid; completes the read |
| tag_data_i | input | 64 | Tag read data |
| xfer_valid_o | output | 1 | Quadword transfer request |
| xfer_addr_o | output | 32 | Quadword address of the transfer |
| xfer_tag_o | output | 1 | Transfer carries the tag itself |
| xfer_ready_i | input | 1 | Mover accepts the transfer |
| done_o | output | 1 | One-cycle pulse when the chain ends |
| irq_o | output | 1 | One-cycle pulse on a tag interrupt stop |
| err_o | output | 1 | Stack overflow flag, held until the next start |

## Verification
The assertions assume that tag_valid_i is raised only while tag_req_o is high. They also assume the environment does not rely on a control write landing while the channel runs. The bench's memory model ties tag_valid_i directly to tag_req_o, and it issues a write to a running channel in only one place, where it checks that the write is dropped. Ready is held high, held low, or toggled every cycle. The bench does not change it in ways that depend on the design's internal state, so every stall stays a plain back-pressure pattern.

// File: rtl/dma_chain_seq_pkg.sv
package dma_chain_seq_pkg;

  typedef enum logic [2:0] {
    TG_REFE = 3'd0,
    TG_CNT  = 3'd1,
    TG_NEXT = 3'd2,
    TG_REF  = 3'd3,
    TG_REFS = 3'd4,
    TG_CALL = 3'd5,
    TG_RET  = 3'd6,
    TG_END  = 3'd7
  } tag_id_e;

  typedef enum logic [2:0] {
    NX_STOP,
    NX_AFTER_DATA,
    NX_FIELD,
    NX_AFTER_TAG,
    NX_POP
  } next_e;

  typedef struct packed {
    logic [31:0] addr;
    logic        irq;
    tag_id_e     id;
    logic [1:0]  pce;
    logic [9:0]  rsvd;
    logic [15:0] qwc;
  } tag_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_TAGX,
    ST_DATA,
    ST_LINK
  } state_e;

  localparam logic [1:0] MODE_CHAIN = 2'd1;

endpackage

// File: rtl/dcs_addr_step.sv
module dcs_addr_step #(
  parameter int unsigned SPR_AW = 10
) (
  input  logic [31:0] addr_i,
  output logic [31:0] addr_o
);
  localparam int unsigned HI_W = 31 - SPR_AW;

  logic [SPR_AW-1:0] low_inc;
  assign low_inc = addr_i[SPR_AW-1:0] + 1'b1;

  // scratchpad addresses wrap in the window, others carry normally
  always_comb begin
    if (addr_i[31]) addr_o = {1'b1, {HI_W{1'b0}}, low_inc};
    else            addr_o = {1'b0, addr_i[30:0] + 31'd1};
  end
endmodule

// File: rtl/dcs_tag_decode.sv
module dcs_tag_decode
  import dma_chain_seq_pkg::*;
(
  input  tag_t  tag_i,
  output logic  src_field_o,
  output next_e next_o,
  output logic  push_o
);
  always_comb begin
    src_field_o = 1'b0;
    push_o      = 1'b0;
    next_o      = NX_STOP;
    unique case (tag_i.id)
      TG_REFE: begin src_field_o = 1'b1; next_o = NX_STOP; end
      TG_CNT:  next_o = NX_AFTER_DATA;
      TG_NEXT: next_o = NX_FIELD;
      TG_REF,
      TG_REFS: begin src_field_o = 1'b1; next_o = NX_AFTER_TAG; end
      TG_CALL: begin next_o = NX_FIELD; push_o = 1'b1; end
      TG_RET:  next_o = NX_POP;
      TG_END:  next_o = NX_STOP;
      default: next_o = NX_STOP;
    endcase
  end
endmodule

// File: rtl/dcs_ret_stack.sv
module dcs_ret_stack #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned SP_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SP_W-1:0] sp_i,
  input  logic            push_i,
  input  logic [31:0]     data_i,
  output logic [31:0]     top_o
);
  logic [31:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                ent_q[g] <= '0;
      else if (push_i && sp_i == SP_W'(g))        ent_q[g] <= data_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sp_i == SP_W'(i + 1)) top_o = ent_q[i];
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_seq_pkg::*;
#(
  parameter int unsigned SPR_AW      = 10,
  parameter int unsigned STACK_DEPTH = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] ctrl_wdata_i,
  input  logic [31:0] tadr_i,
  output logic [31:0] ctrl_o,
  output logic        tag_req_o,
  output logic [31:0] tag_addr_o,
  input  logic        tag_valid_i,
  input  logic [63:0] tag_data_i,
  output logic        xfer_valid_o,
  output logic [31:0] xfer_addr_o,
  output logic        xfer_tag_o,
  input  logic        xfer_ready_i,
  output logic        done_o,
  output logic        irq_o,
  output logic        err_o
);
  localparam int unsigned SP_W  = 2;
  localparam int unsigned QWC_W = 16;
  localparam logic [SP_W-1:0] SP_FULL = SP_W'(STACK_DEPTH);

  state_e            state_q;
  logic              dir_q, tte_q, tie_q, start_q;
  logic [1:0]        mode_q;
  logic [SP_W-1:0]   sp_q;
  logic [15:0]       tagu_q;
  logic [31:0]       tadr_q, madr_q, fld_q, after_tag_q;
  logic [QWC_W-1:0]  cnt_q;
  next_e             next_q;
  logic              irq_flag_q;
  logic              done_q, irq_q, err_q;

  tag_t        tag_in;
  logic        dec_src_field, dec_push;
  next_e       dec_next;
  logic [31:0] tadr_inc, madr_inc, stack_top;
  logic        stk_push;
  logic [SP_W-1:0] wr_sp;
  logic        stop_now;

  assign tag_in = tag_t'(tag_data_i);

  dcs_tag_decode u_dec (
    .tag_i       (tag_in),
    .src_field_o (dec_src_field),
    .next_o      (dec_next),
    .push_o      (dec_push)
  );

  dcs_addr_step #(.SPR_AW(SPR_AW)) u_tag_step (
    .addr_i (tadr_q),
    .addr_o (tadr_inc)
  );

  dcs_addr_step #(.SPR_AW(SPR_AW)) u_madr_step (
    .addr_i (madr_q),
    .addr_o (madr_inc)
  );

  dcs_ret_stack #(.DEPTH(STACK_DEPTH), .SP_W(SP_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sp_i   (sp_q),
    .push_i (stk_push),
    .data_i (madr_q),
    .top_o  (stack_top)
  );

  assign stop_now = (next_q == NX_STOP) || (next_q == NX_POP && sp_q == '0) ||
                    (tie_q && irq_flag_q);
  assign stk_push = (state_q == ST_LINK) && !stop_now && (next_q == NX_FIELD) &&
                    (fld_push_q);

  logic fld_push_q;

  // written stack pointer is clamped to the stack depth
  assign wr_sp = (ctrl_wdata_i[5:4] > SP_FULL) ? SP_FULL : ctrl_wdata_i[5:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      dir_q       <= 1'b0;
      mode_q      <= '0;
      sp_q        <= '0;
      tte_q       <= 1'b0;
      tie_q       <= 1'b0;
      start_q     <= 1'b0;
      tagu_q      <= '0;
      tadr_q      <= '0;
      madr_q      <= '0;
      fld_q       <= '0;
      after_tag_q <= '0;
      cnt_q       <= '0;
      next_q      <= NX_STOP;
      irq_flag_q  <= 1'b0;
      fld_push_q  <= 1'b0;
      done_q      <= 1'b0;
      irq_q       <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (ctrl_we_i) begin
            dir_q   <= ctrl_wdata_i[0];
            mode_q  <= ctrl_wdata_i[3:2];
            sp_q    <= wr_sp;
            tte_q   <= ctrl_wdata_i[6];
            tie_q   <= ctrl_wdata_i[7];
            if (ctrl_wdata_i[8] && ctrl_wdata_i[3:2] == MODE_CHAIN) begin
              start_q <= 1'b1;
              tadr_q  <= tadr_i;
              err_q   <= 1'b0;
              state_q <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (tag_valid_i) begin
            tagu_q <= tag_data_i[31:16];
            if (tag_in.id == TG_CALL && sp_q >= SP_FULL) begin
              err_q   <= 1'b1;
              start_q <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              madr_q      <= dec_src_field ? tag_in.addr : tadr_inc;
              after_tag_q <= tadr_inc;
              fld_q       <= tag_in.addr;
              cnt_q       <= tag_in.qwc;
              next_q      <= dec_next;
              fld_push_q  <= dec_push;
              irq_flag_q  <= tag_in.irq;
              state_q     <= tte_q ? ST_TAGX : ST_DATA;
            end
          end
        end
        ST_TAGX: begin
          if (xfer_ready_i) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (cnt_q == '0) begin
            state_q <= ST_LINK;
          end else if (xfer_ready_i) begin
            madr_q <= madr_inc;
            cnt_q  <= cnt_q - 1'b1;
          end
        end
        ST_LINK: begin
          if (stop_now) begin
            start_q <= 1'b0;
            done_q  <= 1'b1;
            irq_q   <= tie_q && irq_flag_q;
            state_q <= ST_IDLE;
          end else begin
            unique case (next_q)
              NX_AFTER_DATA: tadr_q <= madr_q;
              NX_FIELD:      tadr_q <= fld_q;
              NX_AFTER_TAG:  tadr_q <= after_tag_q;
              NX_POP:        tadr_q <= stack_top;
              default:       tadr_q <= tadr_q;
            endcase
            if (stk_push)          sp_q <= sp_q + 1'b1;
            if (next_q == NX_POP)  sp_q <= sp_q - 1'b1;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ctrl_o       = {tagu_q, 7'd0, start_q, tie_q, tte_q, sp_q, mode_q, 1'b0, dir_q};
  assign tag_req_o    = (state_q == ST_FETCH);
  assign tag_addr_o   = tadr_q;
  assign xfer_valid_o = (state_q == ST_TAGX) || (state_q == ST_DATA && cnt_q != '0);
  assign xfer_tag_o   = (state_q == ST_TAGX);
  assign xfer_addr_o  = (state_q == ST_TAGX) ? tadr_q : madr_q;
  assign done_o       = done_q;
  assign irq_o        = irq_q;
  assign err_o        = err_q;

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] ctrl_o,
  input logic        tag_req_o,
  input logic        tag_valid_i,
  input logic [31:0] tag_addr_o,
  input logic        xfer_valid_o,
  input logic        xfer_ready_i,
  input logic [31:0] xfer_addr_o,
  input logic        done_o,
  input logic        irq_o,
  input logic        err_o
);
  a_r12_xfer_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o));

  a_r12_fetch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tag_req_o && !tag_valid_i |=> tag_req_o && $stable(tag_addr_o));

  a_r12_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tag_req_o, xfer_valid_o}));

  a_r6_sp_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[5:4] != 2'd3);

  a_r13_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[8] |-> !tag_req_o && !xfer_valid_o);

  a_r13_done_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ctrl_o[8]);

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_irq_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> done_o);

  a_r7_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_o && !ctrl_o[8]);
endmodule

bind dma_chain_seq dma_chain_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_o       (ctrl_o),
  .tag_req_o    (tag_req_o),
  .tag_valid_i  (tag_valid_i),
  .tag_addr_o   (tag_addr_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_ready_i (xfer_ready_i),
  .xfer_addr_o  (xfer_addr_o),
  .done_o       (done_o),
  .irq_o        (irq_o),
  .err_o        (err_o)
);

// File: tb/dma_chain_seq_tb.sv
`timescale 1ns/1ps
module dma_chain_seq_tb;
  localparam real CLK_P = 5.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [31:0] ctrl_wdata = '0;
  logic [31:0] tadr = '0;
  logic [31:0] ctrl_o;
  logic        tag_req, tag_valid;
  logic [31:0] tag_addr;
  logic [63:0] tag_data;
  logic        xfer_valid, xfer_tag, xfer_ready;
  logic [31:0] xfer_addr;
  logic        done, irq, err;

  logic [63:0] mem [256];
  logic        rdy = 1'b1;
  logic        toggle = 1'b0;
  logic        rdy_t = 1'b0;
  logic        clr_log = 1'b0;
  logic [31:0] log_addr [64];
  logic        log_tag [64];
  int          log_n = 0;
  int          n_done = 0;
  int          n_irq = 0;
  int          checks = 0;
  int          errors = 0;

  always #(CLK_P / 2.0) clk = ~clk;

  dma_chain_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ctrl_we_i    (ctrl_we),
    .ctrl_wdata_i (ctrl_wdata),
    .tadr_i       (tadr),
    .ctrl_o       (ctrl_o),
    .tag_req_o    (tag_req),
    .tag_addr_o   (tag_addr),
    .tag_valid_i  (tag_valid),
    .tag_data_i   (tag_data),
    .xfer_valid_o (xfer_valid),
    .xfer_addr_o  (xfer_addr),
    .xfer_tag_o   (xfer_tag),
    .xfer_ready_i (xfer_ready),
    .done_o       (done),
    .irq_o        (irq),
    .err_o        (err)
  );

  assign tag_valid  = tag_req;
  assign tag_data   = mem[tag_addr[7:0]];
  assign xfer_ready = toggle ? rdy_t : rdy;

  always @(posedge clk) begin
    rdy_t <= ~rdy_t;
    if (clr_log) begin
      log_n  <= 0;
      n_done <= 0;
      n_irq  <= 0;
    end else begin
      if (xfer_valid && xfer_ready && log_n < 64) begin
        log_addr[log_n] <= xfer_addr;
        log_tag[log_n]  <= xfer_tag;
        log_n <= log_n + 1;
      end
      if (done) n_done <= n_done + 1;
      if (irq)  n_irq  <= n_irq + 1;
    end
  end

  function automatic logic [63:0] mk_tag(input logic [2:0] id, input logic [15:0] qwc,
                                          input logic [31:0] addr, input logic irq_f);
    return {addr, irq_f, id, 2'b00, 10'd0, qwc};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic prep();
    for (int i = 0; i < 256; i++) mem[i] = '0;
    toggle = 1'b0;
    rdy = 1'b1;
    @(negedge clk) clr_log = 1'b1;
    @(negedge clk) clr_log = 1'b0;
  endtask

  task automatic write_ctrl(input logic [31:0] val, input logic [31:0] t);
    @(negedge clk);
    ctrl_wdata = val;
    tadr = t;
    ctrl_we = 1'b1;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!ctrl_o[8]) break;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_log(input string req, input int n, input logic [31:0] a0,
                           input logic [31:0] a1, input logic [31:0] a2);
    logic [31:0] exp [3];
    exp[0] = a0; exp[1] = a1; exp[2] = a2;
    check(log_n == n, req, 32'(log_n), 32'(n));
    for (int i = 0; i < n && i < 3; i++)
      check(log_addr[i] == exp[i] && !log_tag[i], req, log_addr[i], exp[i]);
  endtask

  task automatic t_reset();
    check(ctrl_o == 32'd0, "R1 ctrl", ctrl_o, 0);
    check({tag_req, xfer_valid, done, irq, err} == 5'd0, "R1 outputs",
          32'({tag_req, xfer_valid, done, irq, err}), 0);
  endtask

  task automatic t_cnt_end();
    prep();
    mem[8'h10] = mk_tag(3'd1, 16'd2, 32'h0, 1'b0);
    mem[8'h13] = mk_tag(3'd7, 16'd1, 32'h0, 1'b0);
    write_ctrl(32'h104, 32'h10);
    wait_stop();
    check_log("R4 cnt/end", 3, 32'h11, 32'h12, 32'h14);
    check(ctrl_o[31:16] == 16'h7000, "R3 tag upper", 32'(ctrl_o[31:16]), 32'h7000);
    check(n_done == 1, "R13 done pulse", 32'(n_done), 1);
  endtask

  task automatic t_next_ref();
    prep();
    toggle = 1'b1;
    mem[8'h20] = mk_tag(3'd2, 16'd1, 32'h40, 1'b0);
    mem[8'h40] = mk_tag(3'd3, 16'd2, 32'h80, 1'b0);
    mem[8'h41] = mk_tag(3'd0, 16'd1, 32'h90, 1'b0);
    write_ctrl(32'h104, 32'h20);
    wait_stop();
    check(log_n == 4, "R5 ref count", 32'(log_n), 4);
    check(log_addr[0] == 32'h21, "R4 next data", log_addr[0], 32'h21);
    check(log_addr[1] == 32'h80 && log_addr[2] == 32'h81, "R5 ref data", log_addr[2], 32'h81);
    check(log_addr[3] == 32'h90, "R5 refe data", log_addr[3], 32'h90);
    check(ctrl_o[31:16] == 16'h0000 && !ctrl_o[8], "R5 refe stop", ctrl_o, 32'h4);
  endtask

  task automatic t_call_ret();
    prep();
    mem[8'h00] = mk_tag(3'd5, 16'd1, 32'h30, 1'b0);
    mem[8'h30] = mk_tag(3'd5, 16'd0, 32'h50, 1'b0);
    mem[8'h50] = mk_tag(3'd6, 16'd1, 32'h0, 1'b0);
    mem[8'h31] = mk_tag(3'd6, 16'd0, 32'h0, 1'b0);
    mem[8'h02] = mk_tag(3'd6, 16'd0, 32'h0, 1'b0);
    write_ctrl(32'h104, 32'h00);
    wait_stop();
    check_log("R6 call/ret", 2, 32'h01, 32'h51, 32'h0);
    check(ctrl_o[5:4] == 2'd0, "R8 sp empty", 32'(ctrl_o[5:4]), 0);
    check(n_done == 1 && !err, "R8 ret end", 32'(n_done), 1);
  endtask

  task automatic t_overflow();
    prep();
    mem[8'h10] = mk_tag(3'd5, 16'd2, 32'h30, 1'b0);
    write_ctrl(32'h134, 32'h10);
    wait_stop();
    check(ctrl_o[5:4] == 2'd2, "R2 sp clamp", 32'(ctrl_o[5:4]), 2);
    check(err && !ctrl_o[8], "R7 err set", 32'({err, ctrl_o[8]}), 32'h2);
    check(log_n == 0 && n_done == 0, "R7 no data", 32'(log_n), 0);
  endtask

  task automatic t_irq();
    prep();
    mem[8'h10] = mk_tag(3'd1, 16'd1, 32'h0, 1'b1);
    mem[8'h12] = mk_tag(3'd7, 16'd1, 32'h0, 1'b0);
    write_ctrl(32'h184, 32'h10);
    wait_stop();
    check(log_n == 1 && n_irq == 1 && n_done == 1, "R9 irq stop", 32'(log_n), 1);
    prep();
    mem[8'h10] = mk_tag(3'd1, 16'd1, 32'h0, 1'b1);
    mem[8'h12] = mk_tag(3'd7, 16'd1, 32'h0, 1'b0);
    write_ctrl(32'h104, 32'h10);
    wait_stop();
    check_log("R9 irq ignored", 2, 32'h11, 32'h13, 32'h0);
    check(n_irq == 0, "R9 no irq", 32'(n_irq), 0);
  endtask

  task automatic t_tte();
    prep();
    mem[8'h10] = mk_tag(3'd7, 16'd1, 32'h0, 1'b0);
    write_ctrl(32'h144, 32'h10);
    wait_stop();
    check(log_n == 2, "R10 count", 32'(log_n), 2);
    check(log_addr[0] == 32'h10 && log_tag[0], "R10 tag xfer", log_addr[0], 32'h10);
    check(log_addr[1] == 32'h11 && !log_tag[1], "R10 data xfer", log_addr[1], 32'h11);
  endtask

  task automatic t_spr();
    prep();
    mem[8'hFF] = mk_tag(3'd1, 16'd2, 32'h0, 1'b0);
    mem[8'h02] = mk_tag(3'd7, 16'd0, 32'h0, 1'b0);
    write_ctrl(32'h104, 32'h8000_03FF);
    wait_stop();
    check_log("R11 spr wrap", 2, 32'h8000_0000, 32'h8000_0001, 32'h0);
    check(n_done == 1, "R11 next tag", 32'(n_done), 1);
  endtask

  task automatic t_mode();
    prep();
    mem[8'h10] = mk_tag(3'd7, 16'd1, 32'h0, 1'b0);
    write_ctrl(32'h100, 32'h10);
    repeat (10) @(negedge clk);
    check(ctrl_o[15:0] == 16'h0000 && log_n == 0, "R2 normal mode", ctrl_o, 0);
    write_ctrl(32'h109, 32'h10);
    repeat (10) @(negedge clk);
    check(ctrl_o[15:0] == 16'h0009 && log_n == 0, "R2 interleave mode", ctrl_o, 32'h9);
  endtask

  task automatic t_busy();
    prep();
    rdy = 1'b0;
    mem[8'h10] = mk_tag(3'd1, 16'd2, 32'h0, 1'b0);
    mem[8'h13] = mk_tag(3'd7, 16'd1, 32'h0, 1'b0);
    write_ctrl(32'h104, 32'h10);
    repeat (4) @(negedge clk);
    check(xfer_valid && xfer_addr == 32'h11, "R12 hold", xfer_addr, 32'h11);
    write_ctrl(32'h000, 32'h0);
    check(ctrl_o[15:0] == 16'h0104, "R12 write ignored", ctrl_o, 32'h104);
    check(xfer_addr == 32'h11, "R12 hold after write", xfer_addr, 32'h11);
    rdy = 1'b1;
    wait_stop();
    check_log("R12 resume", 3, 32'h11, 32'h12, 32'h14);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cnt_end();
    t_next_ref();
    t_call_ret();
    t_overflow();
    t_irq();
    t_tte();
    t_spr();
    t_mode();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule